// File: doc/BRIEF.md
# Runahead Usefulness Predictor

This block decides whether a core may enter runahead mode when a load that misses the outer cache becomes the oldest instruction. The decision has two parts. The first is a table of 2-bit saturating counters, one per group of static loads, selected by low bits of the load's program counter. The second is a phase throttle that watches how many outer-cache misses recent runahead periods produced. When a window of recent periods was unproductive, the throttle refuses the next few entry opportunities.

The core presents the triggering load PC on the lookup port. One cycle later it receives a registered allow/deny answer. When a runahead period ends, the core presents the PC that started it on the training port. It also gives a flag that says whether the period produced a miss beyond the reach of the normal instruction window, and a count of the outer-cache misses the period generated. The flag moves the counter. The count feeds the throttle window.

Top module: `rh_usefulness_pred`

## Requirements
- R1: After reset every counter holds 2'b10 (weakly useful), the throttle is idle, its period window is empty, and `lk_resp_valid` is 0.
- R2: A lookup is predicted useful when the selected counter has its MSB set (values 2 and 3), and not useful for values 0 and 1.
- R3: A training with `tr_useful`=1 adds one to the selected counter, saturating at 3.
- R4: A training with `tr_useful`=0 subtracts one from the selected counter, saturating at 0.
- R5: The counter index is PC bits [ALIGN_BITS+IDX_W-1:ALIGN_BITS]. With the defaults (64 entries, 2 alignment bits) this is bits [7:2], so PCs that differ only in bits [1:0] or above bit 7 share one counter.
- R6: When a lookup and a training select the same counter in the same cycle, the lookup sees the counter after the training update.
- R7: A lookup accepted in cycle k gives `lk_resp_valid`=1 in cycle k+1 only. No response appears without a lookup.
- R8: The throttle keeps the miss counts of the last WIN_N trainings. When at least WIN_N trainings have occurred since reset or since the last arming, and their counts sum to less than MISS_THR, the throttle arms for SKIP_M lookups and its window restarts empty. A sum of at least MISS_THR does not arm it.
- R9: While the throttle is armed, each lookup answers `lk_throttled`=1 and uses up one opportunity. A lookup in the same cycle as the arming training sees the throttle state from before that training.
- R10: `lk_allow` is the counter prediction ANDed with the throttle not being armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request for a runahead entry opportunity |
| lk_pc | input | PC_W | PC of the triggering load |
| tr_valid | input | 1 | Training at the end of a runahead period |
| tr_pc | input | PC_W | PC of the load that started the period |
| tr_useful | input | 1 | The period produced a miss the window could not capture |
| tr_misses | input | MISS_W | Outer-cache misses generated during the period |
| lk_resp_valid | output | 1 | Registered response to the previous cycle's lookup |
| lk_allow | output | 1 | Entry allowed |
| lk_throttled | output | 1 | Denied (or would be) by the phase throttle |

## Verification
The bench drives counters into both saturation ends and then reverses direction. A counter that wrapped would flip the answer too early or too late. It aliases PCs through the alignment bits and the upper bits, which catches a shifted index slice. A same-cycle lookup and training on one entry is checked against the updated value, so a design that reads before writing returns a stale allow. The throttle is armed with a lookup in the arming cycle. The bench then counts exactly SKIP_M denied opportunities, and it also drives a window whose sum equals the threshold. An off-by-one in the skip count, the window length or the comparison would show up as one lookup too many or too few being denied.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

  typedef logic [1:0] sat2_t;

  localparam sat2_t CTR_RESET = 2'b10;

  // Saturating 2-bit step: up=1 moves toward 3, up=0 toward 0.
  function automatic sat2_t sat2_step(input sat2_t cur, input logic up);
    sat2_t res;
    if (up) begin
      res = (cur == 2'b11) ? cur : cur + 2'b01;
    end else begin
      res = (cur == 2'b00) ? cur : cur - 2'b01;
    end
    return res;
  endfunction

endpackage

// File: rtl/rhp_table.sv
module rhp_table
  import rhp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  output sat2_t            rd_ctr
);

  sat2_t ctr_q [DEPTH];
  sat2_t ctr_d [DEPTH];
  logic  hit   [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_comb begin
        hit[gi]   = wr_en && (wr_idx == IDX_W'(gi));
        ctr_d[gi] = ctr_q[gi];
        if (hit[gi]) begin
          ctr_d[gi] = sat2_step(ctr_q[gi], wr_up);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctr_q[gi] <= CTR_RESET;
        end else if (hit[gi]) begin
          ctr_q[gi] <= ctr_d[gi];
        end
      end

      AST_NO_RISE_ON_USELESS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[gi] && !wr_up) |=> (ctr_q[gi] <= $past(ctr_q[gi]))); // R4

      AST_NO_FALL_ON_USEFUL: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[gi] && wr_up) |=> (ctr_q[gi] >= $past(ctr_q[gi]))); // R3

      AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[gi] |=> $stable(ctr_q[gi])); // R3
    end
  endgenerate

  // Write-first read: the lookup sees the next-state value of its entry.
  always_comb begin
    rd_ctr = ctr_d[rd_idx];
  end

endmodule

// File: rtl/rhp_throttle.sv
module rhp_throttle #(
  parameter int WIN_N    = 4,
  parameter int MISS_THR = 2,
  parameter int SKIP_M   = 8,
  parameter int MISS_W   = 4,
  localparam int SEEN_W  = $clog2(WIN_N + 1),
  localparam int SUM_W   = MISS_W + $clog2(WIN_N + 1),
  localparam int SKIP_W  = $clog2(SKIP_M + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_valid,
  input  logic [MISS_W-1:0] tr_misses,
  input  logic              opp_valid,
  output logic              armed
);

  logic [MISS_W-1:0] hist_q [WIN_N];
  logic [MISS_W-1:0] hist_d [WIN_N];
  logic [SEEN_W-1:0] seen_q, seen_d, seen_inc;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic [SUM_W-1:0]  win_sum;
  logic              trig;

  // Window shift: newest count enters slot 0.
  genvar gi;
  generate
    for (gi = 0; gi < WIN_N; gi++) begin : g_hist
      if (gi == 0) begin : g_head
        always_comb hist_d[gi] = tr_valid ? tr_misses : hist_q[gi];
      end else begin : g_tail
        always_comb hist_d[gi] = tr_valid ? hist_q[gi-1] : hist_q[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q[gi] <= '0;
        end else if (tr_valid) begin
          hist_q[gi] <= hist_d[gi];
        end
      end
    end
  endgenerate

  always_comb begin
    win_sum = '0;
    for (int i = 0; i < WIN_N; i++) begin
      win_sum = win_sum + SUM_W'(hist_d[i]);
    end
  end

  always_comb begin
    seen_inc = (seen_q == SEEN_W'(WIN_N)) ? seen_q : seen_q + SEEN_W'(1);
    trig     = tr_valid && (seen_inc == SEEN_W'(WIN_N)) && (win_sum < SUM_W'(MISS_THR));

    seen_d = seen_q;
    if (trig) begin
      seen_d = '0;
    end else if (tr_valid) begin
      seen_d = seen_inc;
    end

    skip_d = skip_q;
    if (trig) begin
      skip_d = SKIP_W'(SKIP_M);
    end else if (opp_valid && (skip_q != '0)) begin
      skip_d = skip_q - SKIP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (tr_valid) begin
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
    end else if (trig || opp_valid) begin
      skip_q <= skip_d;
    end
  end

  assign armed = (skip_q != '0);

  AST_SKIP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q <= SKIP_W'(SKIP_M)); // R8

  AST_SEEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= SEEN_W'(WIN_N)); // R8

  AST_OPP_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (opp_valid && armed && !trig) |=> (skip_q == $past(skip_q) - SKIP_W'(1))); // R9

  AST_ARM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (skip_q == SKIP_W'(SKIP_M)) && (seen_q == '0)); // R8

  AST_IDLE_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!opp_valid && !trig) |=> $stable(skip_q)); // R9

endmodule

// File: rtl/rh_usefulness_pred.sv
module rh_usefulness_pred
  import rhp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int DEPTH      = 64,
  parameter int WIN_N      = 4,
  parameter int MISS_THR   = 2,
  parameter int SKIP_M     = 8,
  parameter int MISS_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic              tr_valid,
  input  logic [PC_W-1:0]   tr_pc,
  input  logic              tr_useful,
  input  logic [MISS_W-1:0] tr_misses,
  output logic              lk_resp_valid,
  output logic              lk_allow,
  output logic              lk_throttled
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int IDX_LO = ALIGN_BITS;
  localparam int IDX_HI = ALIGN_BITS + IDX_W - 1;

  logic [IDX_W-1:0] lk_idx, tr_idx;
  sat2_t            lk_ctr;
  logic             thr_armed;
  logic             pred_ok;
  logic             resp_valid_d, allow_d, thr_d;
  logic             resp_valid_q, allow_q, thr_q;

  assign lk_idx = lk_pc[IDX_HI:IDX_LO];
  assign tr_idx = tr_pc[IDX_HI:IDX_LO];

  rhp_table #(
    .DEPTH (DEPTH)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_idx),
    .wr_en  (tr_valid),
    .wr_idx (tr_idx),
    .wr_up  (tr_useful),
    .rd_ctr (lk_ctr)
  );

  rhp_throttle #(
    .WIN_N    (WIN_N),
    .MISS_THR (MISS_THR),
    .SKIP_M   (SKIP_M),
    .MISS_W   (MISS_W)
  ) u_throttle (
    .clk       (clk),
    .rst_n     (rst_n),
    .tr_valid  (tr_valid),
    .tr_misses (tr_misses),
    .opp_valid (lk_valid),
    .armed     (thr_armed)
  );

  always_comb begin
    pred_ok      = lk_ctr[1];
    resp_valid_d = lk_valid;
    thr_d        = thr_armed;
    allow_d      = pred_ok && !thr_armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
    end else begin
      resp_valid_q <= resp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q <= 1'b0;
      thr_q   <= 1'b0;
    end else if (lk_valid) begin
      allow_q <= allow_d;
      thr_q   <= thr_d;
    end
  end

  assign lk_resp_valid = resp_valid_q;
  assign lk_allow      = allow_q;
  assign lk_throttled  = thr_q;

  AST_RESP_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_resp_valid |-> $past(lk_valid)); // R7

  AST_LOOKUP_GETS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_resp_valid); // R7

  AST_THROTTLE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_resp_valid && lk_throttled) |-> !lk_allow); // R10

  AST_SAME_IDX_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && tr_valid && (lk_idx == tr_idx) && !thr_armed) |=> (lk_allow == $past(tr_useful) || $past(lk_ctr) == 2'b10 || $past(lk_ctr) == 2'b01)); // R6

endmodule

// File: tb/rh_usefulness_pred_test.sv
module rh_usefulness_pred_test;

  localparam int PC_W   = 32;
  localparam int DEPTH  = 64;
  localparam int WIN_N  = 4;
  localparam int THR    = 2;
  localparam int SKIP_M = 8;
  localparam int MISS_W = 4;

  logic              clk;
  logic              rst_n;
  logic              lk_valid;
  logic [PC_W-1:0]   lk_pc;
  logic              tr_valid;
  logic [PC_W-1:0]   tr_pc;
  logic              tr_useful;
  logic [MISS_W-1:0] tr_misses;
  logic              lk_resp_valid;
  logic              lk_allow;
  logic              lk_throttled;

  rh_usefulness_pred uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_pc         (lk_pc),
    .tr_valid      (tr_valid),
    .tr_pc         (tr_pc),
    .tr_useful     (tr_useful),
    .tr_misses     (tr_misses),
    .lk_resp_valid (lk_resp_valid),
    .lk_allow      (lk_allow),
    .lk_throttled  (lk_throttled)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit    v;
    bit    allow;
    bit    thr;
    string req;
  } exp_t;

  exp_t sb[$];

  // Reference model built from the requirements.
  int mtab [DEPTH];
  int mhist[$];
  int mseen;
  int mskip;

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[7:2]);  // R5
  endfunction

  task automatic check(input string req, input int act, input int exp_v, input string what);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic step(input bit lk, input logic [PC_W-1:0] lpc,
                      input bit tr, input logic [PC_W-1:0] tpc,
                      input bit useful, input int misses, input string req);
    exp_t e;
    int   sum;
    bit   trig;
    @(negedge clk);
    lk_valid  = lk;
    lk_pc     = lpc;
    tr_valid  = tr;
    tr_pc     = tpc;
    tr_useful = useful;
    tr_misses = MISS_W'(misses);
    // Counter update first (R3, R4, R6).
    if (tr) begin
      if (useful) begin
        if (mtab[idx_of(tpc)] < 3) mtab[idx_of(tpc)]++;
      end else begin
        if (mtab[idx_of(tpc)] > 0) mtab[idx_of(tpc)]--;
      end
    end
    e.v   = lk;
    e.thr = (mskip != 0);
    e.allow = (mtab[idx_of(lpc)] >= 2) && !e.thr;  // R2, R10
    e.req = req;
    sb.push_back(e);
    // Throttle update uses state from before this cycle (R9).
    trig = 0;
    if (tr) begin
      mhist.push_front(misses);
      if (mhist.size() > WIN_N) void'(mhist.pop_back());
      if (mseen < WIN_N) mseen++;
      sum = 0;
      foreach (mhist[i]) sum += mhist[i];
      if (mseen == WIN_N && sum < THR) trig = 1;  // R8
    end
    if (trig) begin
      mskip = SKIP_M;
      mseen = 0;
    end else if (lk && mskip != 0) begin
      mskip--;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, 0, "R7");
  endtask

  // Monitor: compare one scoreboard item per cycle.
  always @(posedge clk) begin
    #2;
    if (rst_n && sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, int'(lk_resp_valid), int'(e.v), "resp_valid");
      if (e.v) begin
        check(e.req, int'(lk_allow), int'(e.allow), "allow");
        check(e.req, int'(lk_throttled), int'(e.thr), "throttled");
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mtab[i] = 2;  // R1
    mseen = 0;
    mskip = 0;
    rst_n = 1'b0;
    lk_valid = 0; lk_pc = '0; tr_valid = 0; tr_pc = '0; tr_useful = 0; tr_misses = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", int'(lk_resp_valid), 0, "resp_valid in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: fresh entry is weakly useful.
    step(1, 32'h100, 0, '0, 0, 0, "R1");
    idle(1);

    // R4: useless drop, saturate at 0, climb back.
    step(0, '0, 1, 32'h104, 0, 5, "R4");
    step(1, 32'h104, 0, '0, 0, 0, "R4");
    for (int i = 0; i < 3; i++) step(0, '0, 1, 32'h104, 0, 5, "R4");
    step(0, '0, 1, 32'h104, 1, 5, "R4");
    step(1, 32'h104, 0, '0, 0, 0, "R4");
    step(0, '0, 1, 32'h104, 1, 5, "R2");
    step(1, 32'h104, 0, '0, 0, 0, "R2");

    // R3: saturate at 3, then two steps down.
    for (int i = 0; i < 3; i++) step(0, '0, 1, 32'h108, 1, 5, "R3");
    step(0, '0, 1, 32'h108, 0, 5, "R3");
    step(1, 32'h108, 0, '0, 0, 0, "R3");
    step(0, '0, 1, 32'h108, 0, 5, "R3");
    step(1, 32'h108, 0, '0, 0, 0, "R3");

    // R5: aliasing via alignment bits and upper bits.
    step(0, '0, 1, 32'h10C, 0, 5, "R5");
    step(1, 32'h10F, 0, '0, 0, 0, "R5");
    step(1, 32'h20C, 0, '0, 0, 0, "R5");
    step(1, 32'h110, 0, '0, 0, 0, "R5");

    // R6: same-cycle lookup and training on one entry.
    step(1, 32'h114, 1, 32'h114, 0, 5, "R6");
    step(1, 32'h114, 1, 32'h114, 1, 5, "R6");
    idle(2);

    // R8/R9: four empty periods arm the throttle; lookup in arming cycle sees old state.
    for (int i = 0; i < 3; i++) step(0, '0, 1, 32'h180, 1, 0, "R8");
    step(1, 32'h100, 0, '0, 0, 0, "R8");
    step(1, 32'h100, 1, 32'h180, 1, 0, "R9");
    for (int i = 0; i < SKIP_M; i++) begin
      step(1, 32'h100, 0, '0, 0, 0, "R9");
      idle(1);
    end
    step(1, 32'h100, 0, '0, 0, 0, "R10");
    step(1, 32'h104, 0, '0, 0, 0, "R10");

    // R8: window sum equal to the threshold does not arm.
    for (int i = 0; i < 3; i++) step(0, '0, 1, 32'h180, 1, 0, "R8");
    step(0, '0, 1, 32'h180, 1, THR, "R8");
    step(1, 32'h100, 0, '0, 0, 0, "R8");
    step(0, '0, 1, 32'h180, 1, 0, "R8");
    step(1, 32'h100, 0, '0, 0, 0, "R8");
    // Sliding window drops the nonzero count: arms again.
    for (int i = 0; i < 3; i++) step(0, '0, 1, 32'h180, 1, 0, "R8");
    step(1, 32'h100, 0, '0, 0, 0, "R9");
    step(1, 32'h108, 0, '0, 0, 0, "R10");
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule